// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Prioritizer

This block collects the interrupt conditions of a two-channel serial controller and names the one pending source that wins. Each channel feeds three source groups: a receiver group (character arrivals and receive errors), a transmitter group (buffer-empty strobes) and an external/status group (modem and line condition changes). Each group keeps one registered pending bit. A fixed priority picks among the six bits, and the result is reported as an interrupt line plus a 3-bit source code.

The service routine clears each pending bit with its own clear input. External/status bits are cleared by a reset-status command. The receiver group has four programmable modes. One mode raises an interrupt only for the first character of a message; it is re-armed by an explicit command. A master enable gates the whole output so that software can fall back to polling.

Top module: `sio_irq_prio`

## Requirements
- R1: Source codes are 0 = channel A receive, 1 = channel A transmit, 2 = channel A external/status, 3 = channel B receive, 4 = channel B transmit, 5 = channel B external/status. The lowest pending code wins. `vec_o` = 7 and `irq_o` = 0 when nothing is pending, and `irq_o` is high exactly when `vec_o` is not 7.
- R2: While `mie_i` = 0, `irq_o` = 0 and `vec_o` = 7, and pending bits are kept. Raising `mie_i` reports the winner in the same cycle.
- R3: In receive mode 2 (all characters), every `rx_char_i` strobe sets that channel's receive pending bit.
- R4: In receive mode 1 (first character), the first character after reset or after an `rx_rearm_i` command sets receive pending. Later characters are ignored until the next `rx_rearm_i`.
- R5: In receive mode 3 (special only), characters are ignored and special conditions set receive pending.
- R6: `rx_spec_i` bits are [0] overrun, [1] framing error, [2] end of frame, [3] parity error. Any set bit raises receive pending in modes 1 to 3. Bit [3] counts only while `parity_en_i` is high. Mode 0 ignores characters and special conditions.
- R7: `tx_empty_i` with `tx_ie_i` high sets transmit pending, and `tx_clr_i` clears it. With `tx_ie_i` low the strobe is ignored. A set and a clear in the same cycle leave the bit set.
- R8: `ext_in_i` bits are [0] CTS, [1] DCD, [2] sync/hunt, [3] break/abort, [4] transmit underrun/end of message, [5] zero count. A change of a bit whose `ext_ie_i` bit is high sets external pending. Changes of disabled bits are ignored.
- R9: External pending stays set until `ext_rst_i`, and the input values are frozen at the latch. An enabled input that differs from the frozen value when the clear takes effect sets the bit again one cycle after the clear.
- R10: `rx_clr_i` clears receive pending. A receive set in the same cycle wins over the clear.
- R11: Pending bits update on the clock edge after the strobe, and `vec_o`/`irq_o` follow the registered bits with no path from the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mie_i | input | 1 | Master interrupt enable |
| rx_char_i | input | 2 | Character received strobe, per channel |
| rx_spec_i | input | 2x4 | Special receive condition strobes, per channel |
| parity_en_i | input | 2 | Parity checking enabled, per channel |
| rx_mode_i | input | 2x2 | Receive interrupt mode, per channel |
| rx_rearm_i | input | 2 | Re-arm first-character mode, per channel |
| rx_clr_i | input | 2 | Clear receive pending, per channel |
| tx_empty_i | input | 2 | Transmit buffer became empty strobe, per channel |
| tx_ie_i | input | 2 | Transmit interrupt enable, per channel |
| tx_clr_i | input | 2 | Clear transmit pending, per channel |
| ext_in_i | input | 2x6 | External/status condition levels, per channel |
| ext_ie_i | input | 2x6 | Per-condition external/status enables, per channel |
| ext_rst_i | input | 2 | Reset-status command, per channel |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 3 | Winning source code, 7 = none |

## Verification
On every cycle the assertions check that the master enable silences the output, that the interrupt line and the code agree, and that a pending top source always wins. They also check that an enabled transmit strobe sets its bit, that a latched external bit holds until its reset command, and that characters cannot set receive pending in special-only mode. Only the bench scenarios can show the order of the six-level chain, the first-character arming and re-arming, the parity qualification, and the re-assertion of an external change that arrived while latched. The bench compares every cycle of random traffic against its own model of all pending bits.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
    localparam int SRC_PER_CH  = 3;
    localparam int SPEC_W      = 4;
    localparam int EXT_W       = 6;
    localparam int SPEC_PARITY = 3;
    localparam int SRC_RX      = 0;
    localparam int SRC_TX      = 1;
    localparam int SRC_EXT     = 2;

    typedef enum logic [1:0] {
        RXM_OFF   = 2'd0,
        RXM_FIRST = 2'd1,
        RXM_ALL   = 2'd2,
        RXM_SPEC  = 2'd3
    } rx_mode_e;
endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
    import sio_irq_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  rx_char_i,
    input  logic [SPEC_W-1:0]     rx_spec_i,
    input  logic                  parity_en_i,
    input  logic [1:0]            rx_mode_i,
    input  logic                  rx_rearm_i,
    input  logic                  rx_clr_i,
    input  logic                  tx_empty_i,
    input  logic                  tx_ie_i,
    input  logic                  tx_clr_i,
    input  logic [EXT_W-1:0]      ext_in_i,
    input  logic [EXT_W-1:0]      ext_ie_i,
    input  logic                  ext_rst_i,
    output logic [SRC_PER_CH-1:0] pend_o
);
    typedef struct packed {
        logic             rx_pend;
        logic             armed;
        logic             tx_pend;
        logic             ext_pend;
        logic [EXT_W-1:0] snap;
    } chan_st_t;

    chan_st_t         st_d, st_q;
    rx_mode_e         mode;
    logic [SPEC_W-1:0] spec_m;
    logic             spec_hit, char_hit;
    logic [EXT_W-1:0] ext_diff;

    assign mode = rx_mode_e'(rx_mode_i);

    always_comb begin
        st_d   = st_q;
        spec_m = rx_spec_i;
        spec_m[SPEC_PARITY] = rx_spec_i[SPEC_PARITY] & parity_en_i;
        spec_hit = (mode != RXM_OFF) && (|spec_m);
        char_hit = rx_char_i &&
                   ((mode == RXM_ALL) || ((mode == RXM_FIRST) && st_q.armed));

        // receive group: a new event outranks the clear
        st_d.rx_pend = spec_hit | char_hit | (st_q.rx_pend & ~rx_clr_i);
        if (rx_rearm_i) begin
            st_d.armed = 1'b1;
        end else if (rx_char_i && (mode == RXM_FIRST)) begin
            st_d.armed = 1'b0;
        end

        // transmit group
        st_d.tx_pend = (tx_empty_i & tx_ie_i) | (st_q.tx_pend & ~tx_clr_i);

        // external/status group: freeze the snapshot while latched
        ext_diff = (ext_in_i ^ st_q.snap) & ext_ie_i;
        if (st_q.ext_pend) begin
            if (ext_rst_i) begin
                st_d.ext_pend = 1'b0;
            end
        end else begin
            st_d.ext_pend = |ext_diff;
            st_d.snap     = ext_in_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{rx_pend: 1'b0, armed: 1'b1, tx_pend: 1'b0,
                      ext_pend: 1'b0, snap: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o[SRC_RX]  = st_q.rx_pend;
    assign pend_o[SRC_TX]  = st_q.tx_pend;
    assign pend_o[SRC_EXT] = st_q.ext_pend;
endmodule

// File: rtl/sio_irq_pick.sv
module sio_irq_pick #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic         en_i,
    input  logic [N-1:0] req_i,
    output logic         vld_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        vld_o = 1'b0;
        idx_o = '1;
        if (en_i) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req_i[i]) begin
                    vld_o = 1'b1;
                    idx_o = W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
    import sio_irq_pkg::*;
#(
    parameter  int NCH   = 2,
    localparam int NSRC  = NCH * SRC_PER_CH,
    localparam int VEC_W = $clog2(NSRC + 1)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        mie_i,
    input  logic [NCH-1:0]              rx_char_i,
    input  logic [NCH-1:0][SPEC_W-1:0]  rx_spec_i,
    input  logic [NCH-1:0]              parity_en_i,
    input  logic [NCH-1:0][1:0]         rx_mode_i,
    input  logic [NCH-1:0]              rx_rearm_i,
    input  logic [NCH-1:0]              rx_clr_i,
    input  logic [NCH-1:0]              tx_empty_i,
    input  logic [NCH-1:0]              tx_ie_i,
    input  logic [NCH-1:0]              tx_clr_i,
    input  logic [NCH-1:0][EXT_W-1:0]   ext_in_i,
    input  logic [NCH-1:0][EXT_W-1:0]   ext_ie_i,
    input  logic [NCH-1:0]              ext_rst_i,
    output logic                        irq_o,
    output logic [VEC_W-1:0]            vec_o
);
    logic [NSRC-1:0] pend;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        sio_irq_chan u_chan (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .rx_char_i   (rx_char_i[ch]),
            .rx_spec_i   (rx_spec_i[ch]),
            .parity_en_i (parity_en_i[ch]),
            .rx_mode_i   (rx_mode_i[ch]),
            .rx_rearm_i  (rx_rearm_i[ch]),
            .rx_clr_i    (rx_clr_i[ch]),
            .tx_empty_i  (tx_empty_i[ch]),
            .tx_ie_i     (tx_ie_i[ch]),
            .tx_clr_i    (tx_clr_i[ch]),
            .ext_in_i    (ext_in_i[ch]),
            .ext_ie_i    (ext_ie_i[ch]),
            .ext_rst_i   (ext_rst_i[ch]),
            .pend_o      (pend[ch*SRC_PER_CH +: SRC_PER_CH])
        );
    end

    sio_irq_pick #(.N(NSRC), .W(VEC_W)) u_pick (
        .en_i  (mie_i),
        .req_i (pend),
        .vld_o (irq_o),
        .idx_o (vec_o)
    );
endmodule

// File: rtl/sio_irq_prio_chk.sv
module sio_irq_prio_chk
    import sio_irq_pkg::*;
#(
    parameter  int NCH   = 2,
    localparam int NSRC  = NCH * SRC_PER_CH,
    localparam int VEC_W = $clog2(NSRC + 1)
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       mie_i,
    input logic [NCH-1:0]             rx_char_i,
    input logic [NCH-1:0][SPEC_W-1:0] rx_spec_i,
    input logic [NCH-1:0][1:0]        rx_mode_i,
    input logic [NCH-1:0]             tx_empty_i,
    input logic [NCH-1:0]             tx_ie_i,
    input logic [NCH-1:0]             ext_rst_i,
    input logic [NSRC-1:0]            pend,
    input logic                       irq_o,
    input logic [VEC_W-1:0]           vec_o
);
    localparam logic [VEC_W-1:0] NONE = '1;

    p_mie_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mie_i |-> (!irq_o && vec_o == NONE));

    p_irq_vec_agree_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (vec_o != NONE));

    p_top_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mie_i && pend[0]) |-> (vec_o == '0));

    p_vec_is_pending_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && vec_o < VEC_W'(NSRC)) |-> pend[vec_o]);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        p_tx_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tx_empty_i[c] && tx_ie_i[c]) |=> pend[c*SRC_PER_CH + SRC_TX]);

        p_ext_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pend[c*SRC_PER_CH + SRC_EXT] && !ext_rst_i[c])
                |=> pend[c*SRC_PER_CH + SRC_EXT]);

        p_spec_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rx_mode_i[c] == RXM_SPEC && rx_char_i[c] && !(|rx_spec_i[c])
             && !pend[c*SRC_PER_CH + SRC_RX])
                |=> !pend[c*SRC_PER_CH + SRC_RX]);
    end
endmodule

bind sio_irq_prio sio_irq_prio_chk #(.NCH(NCH)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mie_i      (mie_i),
    .rx_char_i  (rx_char_i),
    .rx_spec_i  (rx_spec_i),
    .rx_mode_i  (rx_mode_i),
    .tx_empty_i (tx_empty_i),
    .tx_ie_i    (tx_ie_i),
    .ext_rst_i  (ext_rst_i),
    .pend       (pend),
    .irq_o      (irq_o),
    .vec_o      (vec_o)
);

// File: tb/sio_irq_prio_bench.sv
module sio_irq_prio_bench;
    import sio_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                       mie;
    logic [NCH-1:0]             rx_char, parity_en, rx_rearm, rx_clr;
    logic [NCH-1:0]             tx_empty, tx_ie, tx_clr, ext_rst;
    logic [NCH-1:0][SPEC_W-1:0] rx_spec;
    logic [NCH-1:0][1:0]        rx_mode;
    logic [NCH-1:0][EXT_W-1:0]  ext_in, ext_ie;
    logic                       irq;
    logic [2:0]                 vec;

    sio_irq_prio u_sio_irq_prio (
        .clk_i(clk), .rst_ni(rst_n), .mie_i(mie),
        .rx_char_i(rx_char), .rx_spec_i(rx_spec), .parity_en_i(parity_en),
        .rx_mode_i(rx_mode), .rx_rearm_i(rx_rearm), .rx_clr_i(rx_clr),
        .tx_empty_i(tx_empty), .tx_ie_i(tx_ie), .tx_clr_i(tx_clr),
        .ext_in_i(ext_in), .ext_ie_i(ext_ie), .ext_rst_i(ext_rst),
        .irq_o(irq), .vec_o(vec)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state, derived from the requirements
    logic             m_rx[NCH], m_arm[NCH], m_tx[NCH], m_ext[NCH];
    logic [EXT_W-1:0] m_snap[NCH];

    function automatic logic [2:0] ref_vec(logic [5:0] p, logic en);
        for (int i = 0; i < 6; i++) if (en && p[i]) return 3'(i);
        return 3'd7;
    endfunction

    function automatic logic [5:0] m_pend();
        return {m_ext[1], m_tx[1], m_rx[1], m_ext[0], m_tx[0], m_rx[0]};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_rx[c] = 0; m_arm[c] = 1; m_tx[c] = 0; m_ext[c] = 0; m_snap[c] = '0;
        end
    endtask

    task automatic strobes_off();
        rx_char = '0; rx_spec = '0; rx_rearm = '0; rx_clr = '0;
        tx_empty = '0; tx_clr = '0; ext_rst = '0;
    endtask

    // one clock: predict, clock, compare whole output (R1 order, R2 gating)
    task automatic step();
        logic             n_rx[NCH], n_arm[NCH], n_tx[NCH], n_ext[NCH];
        logic [EXT_W-1:0] n_snap[NCH];
        logic [5:0]       exp_p;
        for (int c = 0; c < NCH; c++) begin
            logic [SPEC_W-1:0] sp;
            logic              sh, chh;
            sp  = rx_spec[c] & {parity_en[c], 3'b111};
            sh  = (rx_mode[c] != 2'd0) && (|sp);
            chh = rx_char[c] && (rx_mode[c] == 2'd2 || (rx_mode[c] == 2'd1 && m_arm[c]));
            n_rx[c]  = sh | chh | (m_rx[c] & ~rx_clr[c]);
            n_arm[c] = rx_rearm[c] ? 1'b1 :
                       (rx_char[c] && rx_mode[c] == 2'd1) ? 1'b0 : m_arm[c];
            n_tx[c]  = (tx_empty[c] & tx_ie[c]) | (m_tx[c] & ~tx_clr[c]);
            if (m_ext[c]) begin
                n_ext[c]  = ~ext_rst[c];
                n_snap[c] = m_snap[c];
            end else begin
                n_ext[c]  = |((ext_in[c] ^ m_snap[c]) & ext_ie[c]);
                n_snap[c] = ext_in[c];
            end
        end
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) begin
            m_rx[c] = n_rx[c]; m_arm[c] = n_arm[c]; m_tx[c] = n_tx[c];
            m_ext[c] = n_ext[c]; m_snap[c] = n_snap[c];
        end
        exp_p = m_pend();
        chk("R1/R2 vec vs model", 32'(vec), 32'(ref_vec(exp_p, mie)));
        chk("R1/R2 irq vs model", 32'(irq), 32'(mie && (|exp_p)));
    endtask

    task automatic expect_vec(string tag, logic [2:0] e);
        chk(tag, 32'(vec), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mie = 1'b1; parity_en = '0; rx_mode = '0; tx_ie = '0;
        ext_in = '0; ext_ie = '0;
        strobes_off();
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2) rst_n = 1'b1;
        #1;
        expect_vec("R1 reset none pending", 3'd7);
        chk("R1 reset irq low", 32'(irq), 32'd0);

        // R3 and R11: every character in mode 2, registered latency
        rx_mode[0] = 2'd2;
        rx_char[0] = 1'b1; #1;
        expect_vec("R11 no combinational path from strobe", 3'd7);
        step(); strobes_off();
        expect_vec("R3 first char sets", 3'd0);
        rx_clr[0] = 1; step(); strobes_off();
        rx_char[0] = 1; step(); strobes_off();
        expect_vec("R3 second char sets", 3'd0);
        rx_clr[0] = 1; step(); strobes_off();

        // R1: full chain, peeled off one at a time
        rx_mode = {2'd2, 2'd2}; tx_ie = '1; ext_ie = {6'h3F, 6'h3F};
        rx_char = '1; tx_empty = '1; ext_in = {6'h01, 6'h01};
        step(); strobes_off();
        expect_vec("R1 all pending A rx", 3'd0);
        rx_clr[0] = 1; step(); strobes_off(); expect_vec("R1 A tx next", 3'd1);
        tx_clr[0] = 1; step(); strobes_off(); expect_vec("R1 A ext next", 3'd2);
        ext_rst[0] = 1; step(); strobes_off(); expect_vec("R1 B rx next", 3'd3);
        rx_clr[1] = 1; step(); strobes_off(); expect_vec("R1 B tx next", 3'd4);
        tx_clr[1] = 1; step(); strobes_off(); expect_vec("R1 B ext next", 3'd5);
        ext_rst[1] = 1; step(); strobes_off(); expect_vec("R1 none left", 3'd7);

        // R2: master enable gating keeps pending bits
        rx_char[1] = 1; tx_empty[0] = 1; step(); strobes_off();
        mie = 0; #1;
        expect_vec("R2 gated vec", 3'd7);
        chk("R2 gated irq", 32'(irq), 32'd0);
        step(); step();
        mie = 1; #1;
        expect_vec("R2 enable reveals winner", 3'd1);
        rx_clr[1] = 1; tx_clr[0] = 1; step(); strobes_off();

        // R4: first-character mode on channel B
        rx_mode[1] = 2'd1;
        rx_char[1] = 1; step(); strobes_off();
        expect_vec("R4 first char", 3'd3);
        rx_clr[1] = 1; step(); strobes_off();
        rx_char[1] = 1; step(); strobes_off();
        expect_vec("R4 later char ignored", 3'd7);
        rx_rearm[1] = 1; step(); strobes_off();
        expect_vec("R4 rearm alone no irq", 3'd7);
        rx_char[1] = 1; step(); strobes_off();
        expect_vec("R4 char after rearm", 3'd3);
        rx_clr[1] = 1; step(); strobes_off();

        // R5: special-only mode on channel A
        rx_mode[0] = 2'd3;
        rx_char[0] = 1; step(); strobes_off();
        expect_vec("R5 char ignored", 3'd7);
        rx_spec[0] = 4'b0001; step(); strobes_off();
        expect_vec("R5 overrun interrupts", 3'd0);
        rx_clr[0] = 1; step(); strobes_off();

        // R6: parity qualification and mode 0
        rx_mode[0] = 2'd2; parity_en[0] = 0;
        rx_spec[0] = 4'b1000; step(); strobes_off();
        expect_vec("R6 parity ignored when disabled", 3'd7);
        parity_en[0] = 1;
        rx_spec[0] = 4'b1000; step(); strobes_off();
        expect_vec("R6 parity counts when enabled", 3'd0);
        rx_clr[0] = 1; step(); strobes_off();
        rx_mode[0] = 2'd0;
        rx_spec[0] = 4'b0110; rx_char[0] = 1; step(); strobes_off();
        expect_vec("R6 mode 0 ignores all", 3'd7);

        // R7: transmit enable and set-over-clear
        tx_ie[1] = 0; tx_empty[1] = 1; step(); strobes_off();
        expect_vec("R7 disabled empty ignored", 3'd7);
        tx_ie[1] = 1; tx_empty[1] = 1; tx_clr[1] = 1; step(); strobes_off();
        expect_vec("R7 set wins over clear", 3'd4);
        tx_clr[1] = 1; step(); strobes_off();
        expect_vec("R7 clear", 3'd7);

        // R8: per-condition enables
        ext_ie[0] = 6'b000010;
        ext_in[0] = ext_in[0] ^ 6'b000001; step();
        expect_vec("R8 disabled change ignored", 3'd7);
        ext_in[0] = ext_in[0] ^ 6'b000010; step();
        expect_vec("R8 DCD change latches", 3'd2);

        // R9: hold, clear, re-assert of a change seen while latched
        ext_in[0] = ext_in[0] ^ 6'b000010; step();
        expect_vec("R9 held while latched", 3'd2);
        ext_rst[0] = 1; step(); strobes_off();
        expect_vec("R9 cleared by reset command", 3'd7);
        step();
        expect_vec("R9 late change re-asserts", 3'd2);
        ext_rst[0] = 1; step(); strobes_off();
        step();
        expect_vec("R9 no further change stays clear", 3'd7);

        // R10: receive clear and set-over-clear
        rx_mode[0] = 2'd2;
        rx_char[0] = 1; rx_clr[0] = 1; step(); strobes_off();
        expect_vec("R10 set wins over clear", 3'd0);
        rx_clr[0] = 1; step(); strobes_off();
        expect_vec("R10 clear", 3'd7);

        // random simultaneous traffic against the model
        for (int n = 0; n < 4000; n++) begin
            mie = ($urandom % 10) != 0;
            for (int c = 0; c < NCH; c++) begin
                rx_char[c]  = ($urandom % 3) == 0;
                rx_spec[c]  = (($urandom % 6) == 0) ? 4'($urandom) : 4'd0;
                if (($urandom % 40) == 0) rx_mode[c] = 2'($urandom);
                if (($urandom % 40) == 0) parity_en[c] = ~parity_en[c];
                rx_rearm[c] = ($urandom % 15) == 0;
                rx_clr[c]   = ($urandom % 5) == 0;
                tx_empty[c] = ($urandom % 6) == 0;
                if (($urandom % 30) == 0) tx_ie[c] = ~tx_ie[c];
                tx_clr[c]   = ($urandom % 5) == 0;
                if (($urandom % 8) == 0) ext_in[c] = ext_in[c] ^ 6'(1 << ($urandom % 6));
                if (($urandom % 40) == 0) ext_ie[c] = 6'($urandom);
                ext_rst[c]  = ($urandom % 6) == 0;
            end
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule